// File: doc/BRIEF.md
# Hub Status Change Interrupt Endpoint

This block decides what a four-port hub's interrupt endpoint sends when the host polls it. Change events for the hub itself and for each downstream port are gathered during a frame. Once per frame they are folded into a one-byte change bitmap, at an end-of-frame marker that falls a fixed number of bit times before the next start-of-frame is due. When an IN token for this endpoint arrives, the block answers with the bitmap if any bit is set and with a NAK if none is. While the hub is not configured, it does not answer at all.

The block also holds the frame timer that produces the marker. The timer runs on the 12 MHz bit clock, and every received SOF restarts it. If SOFs stop arriving, the timer wraps once per frame length on its own. Bits stay set across polls until the host clears them one by one with clear requests. Token decoding, CRC and serialisation are handled elsewhere.

Top module: `hub_intr_ep`

## Requirements
- R1: With no SOF received, `eof2_o` pulses for one cycle and then again every FRAME_LEN cycles.
- R2: A cycle with `sof_i` high restarts the frame timer. `eof2_o` next pulses FRAME_LEN-EOF2_LEAD cycles after the edge that took the SOF.
- R3: A change event becomes visible in the bitmap only at the sample edge that follows the next `eof2_o` pulse. Bit 0 is the hub change and bit k is the change on port k (1..4).
- R4: Bitmap bits 7:5 always read zero.
- R5: When configured, an IN token with a nonzero bitmap gives a response one cycle later: `resp_valid_o`=1, `resp_data_o`=1, and `bitmap_o` carries the bitmap as it stood at the token edge.
- R6: When configured, an IN token with an all-zero bitmap gives `resp_valid_o`=1, `resp_data_o`=0 (NAK) and `bitmap_o`=0. `bitmap_o` is zero in every cycle that carries no data response.
- R7: A set bit keeps being reported on every poll until a clear request (`clr_i` bit with the same index) removes it.
- R8: A clear that coincides with a sample edge removes the old value. A change event on that bit during the ending frame sets the bit again at that same edge.
- R9: While `configured_i` is low, an IN token gets no response and change events are ignored.
- R10: When `configured_i` goes low, the bitmap and any pending events are wiped, so the first poll after reconfiguring gets a NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | One-cycle strobe for a received SOF |
| configured_i | input | 1 | Hub is enumerated and configured |
| hub_chg_i | input | 1 | Hub change event strobe |
| port_chg_i | input | NUM_PORTS | Per-port change event strobes |
| clr_i | input | NUM_PORTS+1 | Per-bit clear requests (bit 0 hub, bit k port k) |
| in_tok_i | input | 1 | IN token for this endpoint |
| eof2_o | output | 1 | Late end-of-frame sample marker |
| resp_valid_o | output | 1 | A handshake decision is presented |
| resp_data_o | output | 1 | 1: send bitmap, 0: NAK |
| bitmap_o | output | 8 | Change bitmap sent with a data response |

## Verification
A wrong frame count moves `eof2_o` by one or more cycles, and a cycle-by-cycle comparison catches that within one frame. A corrupted bitmap bit, a lost pending event or a missed clear does not show until the next IN token, and then it appears as a wrong byte or as NAK in place of data. Because bits persist, one bad sample stays visible on every later poll until it is cleared. Faults in the configured gating show as a response while unconfigured, or as stale data after reconfiguration.

// File: rtl/hub_ep_pkg.sv
package hub_ep_pkg;
  typedef enum logic {
    HS_NAK  = 1'b0,
    HS_DATA = 1'b1
  } hs_e;

  function automatic int unsigned map_bytes(int unsigned nbits);
    return (nbits + 7) / 8;
  endfunction
endpackage

// File: rtl/hub_frame_timer.sv
module hub_frame_timer #(
  parameter int unsigned FRAME_LEN = 12000,
  parameter int unsigned EOF2_LEAD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  output logic eof2_o
);
  localparam int unsigned CNT_W   = $clog2(FRAME_LEN);
  localparam int unsigned EOF2_AT = FRAME_LEN - EOF2_LEAD;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] MARK_C = CNT_W'(EOF2_AT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (sof_i)           cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign eof2_o = (cnt_q == MARK_C);

  // R2
  sof_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> cnt_q == '0);
  // R1
  eof2_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof2_o |=> !eof2_o);
endmodule

// File: rtl/hub_chg_sampler.sv
module hub_chg_sampler #(
  parameter int unsigned NBITS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_i,
  input  logic             smp_i,
  input  logic [NBITS-1:0] evt_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] chg_o
);
  logic [NBITS-1:0] pend_q;
  logic [NBITS-1:0] chg_q;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic pend_eff;
    assign pend_eff = pend_q[b] | evt_i[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[b] <= 1'b0;
        chg_q[b]  <= 1'b0;
      end else if (!cfg_i) begin
        pend_q[b] <= 1'b0;
        chg_q[b]  <= 1'b0;
      end else begin
        pend_q[b] <= smp_i ? 1'b0 : pend_eff;
        // clear first; a fresh event on the sample edge wins
        chg_q[b]  <= (chg_q[b] & ~clr_i[b]) | (smp_i & pend_eff);
      end
    end
  end

  assign chg_o = chg_q;

  // R10
  unconfig_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i |=> chg_q == '0);
  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i && !smp_i && clr_i == '0) |=> chg_q == $past(chg_q));
endmodule

// File: rtl/hub_in_resp.sv
module hub_in_resp
  import hub_ep_pkg::*;
#(
  parameter int unsigned NBITS = 5,
  parameter int unsigned MAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_i,
  input  logic             in_tok_i,
  input  logic [NBITS-1:0] chg_i,
  output logic             resp_valid_o,
  output logic             resp_data_o,
  output logic [MAP_W-1:0] bitmap_o
);
  hs_e              hs_d, hs_q;
  logic             vld_q;
  logic [MAP_W-1:0] map_d, map_q;

  always_comb begin
    map_d = '0;
    hs_d  = HS_NAK;
    if (|chg_i) begin
      hs_d             = HS_DATA;
      map_d[NBITS-1:0] = chg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hs_q  <= HS_NAK;
      map_q <= '0;
    end else if (in_tok_i && cfg_i) begin
      vld_q <= 1'b1;
      hs_q  <= hs_d;
      map_q <= map_d;
    end else begin
      vld_q <= 1'b0;
      hs_q  <= HS_NAK;
      map_q <= '0;
    end
  end

  assign resp_valid_o = vld_q;
  assign resp_data_o  = (hs_q == HS_DATA);
  assign bitmap_o     = map_q;

  // R9
  silent_unconfig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tok_i && !cfg_i) |=> !resp_valid_o);
  // R6
  nak_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_data_o |-> bitmap_o == '0);
  // R5
  data_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_tok_i && cfg_i && chg_i != '0) |=> resp_valid_o && resp_data_o);
endmodule

// File: rtl/hub_intr_ep.sv
module hub_intr_ep
  import hub_ep_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned FRAME_LEN = 12000,
  parameter int unsigned EOF2_LEAD = 10,
  localparam int unsigned NBITS    = NUM_PORTS + 1,
  localparam int unsigned MAP_W    = 8 * map_bytes(NBITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 configured_i,
  input  logic                 hub_chg_i,
  input  logic [NUM_PORTS-1:0] port_chg_i,
  input  logic [NUM_PORTS:0]   clr_i,
  input  logic                 in_tok_i,
  output logic                 eof2_o,
  output logic                 resp_valid_o,
  output logic                 resp_data_o,
  output logic [MAP_W-1:0]     bitmap_o
);
  logic             eof2;
  logic [NBITS-1:0] evt;
  logic [NBITS-1:0] chg;

  assign evt = {port_chg_i, hub_chg_i};

  hub_frame_timer #(.FRAME_LEN(FRAME_LEN), .EOF2_LEAD(EOF2_LEAD)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sof_i (sof_i),
    .eof2_o(eof2)
  );

  hub_chg_sampler #(.NBITS(NBITS)) i_sampler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (configured_i),
    .smp_i (eof2),
    .evt_i (evt),
    .clr_i (clr_i),
    .chg_o (chg)
  );

  hub_in_resp #(.NBITS(NBITS), .MAP_W(MAP_W)) i_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (configured_i),
    .in_tok_i    (in_tok_i),
    .chg_i       (chg),
    .resp_valid_o(resp_valid_o),
    .resp_data_o (resp_data_o),
    .bitmap_o    (bitmap_o)
  );

  assign eof2_o = eof2;

  // R3
  sample_only_eof2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eof2 && configured_i) |=> (chg & ~$past(chg)) == '0);
endmodule

// File: tb/test_hub_intr_ep.sv
module test_hub_intr_ep;
  localparam int FL   = 120;
  localparam int LEAD = 10;
  localparam int AT   = FL - LEAD;
  localparam int WD   = 50000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sof_i = 1'b0, configured_i = 1'b0, hub_chg_i = 1'b0, in_tok_i = 1'b0;
  logic [3:0] port_chg_i = '0;
  logic [4:0] clr_i = '0;
  logic       eof2_o, resp_valid_o, resp_data_o;
  logic [7:0] bitmap_o;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hub_intr_ep #(.NUM_PORTS(4), .FRAME_LEN(FL), .EOF2_LEAD(LEAD)) i_hub_intr_ep (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof_i), .configured_i(configured_i),
    .hub_chg_i(hub_chg_i), .port_chg_i(port_chg_i), .clr_i(clr_i),
    .in_tok_i(in_tok_i), .eof2_o(eof2_o), .resp_valid_o(resp_valid_o),
    .resp_data_o(resp_data_o), .bitmap_o(bitmap_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // behavioural reference
  int         m_cnt = 0;
  logic [4:0] m_pend = '0, m_reg = '0;
  logic       m_rv = 1'b0, m_rd = 1'b0;
  logic [7:0] m_bm = '0;

  always @(posedge clk) begin
    logic [4:0] ev;
    bit smp;
    if (!rst_ni) begin
      m_cnt = 0; m_pend = '0; m_reg = '0; m_rv = 0; m_rd = 0; m_bm = '0;
    end else begin
      ev  = {port_chg_i, hub_chg_i};
      smp = (m_cnt == AT);
      m_rv = in_tok_i && configured_i;
      m_rd = m_rv && (m_reg != 0);
      m_bm = m_rd ? {3'b000, m_reg} : 8'h00;
      if (!configured_i) begin
        m_reg = '0; m_pend = '0;
      end else begin
        m_reg  = (m_reg & ~clr_i) | (smp ? (m_pend | ev) : 5'b0);
        m_pend = smp ? 5'b0 : (m_pend | ev);
      end
      if (sof_i || m_cnt == FL - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R1 eof2_o", eof2_o, m_cnt == AT);
      chk("R9 resp_valid_o", resp_valid_o, m_rv);
      chk("R6 resp_data_o", resp_data_o, m_rd);
      chk("R5 bitmap_o", bitmap_o, m_bm);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD && !done) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected<%0d", cyc, WD);
      summary();
      $finish;
    end
  end

  task automatic poll(string tag, bit exp_v, bit exp_d, int exp_bm);
    in_tok_i = 1'b1;
    @(negedge clk);
    in_tok_i = 1'b0;
    chk({tag, " valid"}, resp_valid_o, exp_v);
    chk({tag, " data"}, resp_data_o, exp_d);
    chk({tag, " map"}, bitmap_o, exp_bm);
  endtask

  task automatic pass_eof2();
    while (!eof2_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_evt(bit hub, logic [3:0] ports);
    hub_chg_i = hub; port_chg_i = ports;
    @(negedge clk);
    hub_chg_i = 1'b0; port_chg_i = '0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 reset valid", resp_valid_o, 0);
    chk("R6 reset map", bitmap_o, 0);
    poll("R9 unconfigured poll", 0, 0, 0);
    configured_i = 1'b1;
    repeat (7) @(negedge clk);

    // R2: SOF restarts timer
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
    n = 0;
    while (!eof2_o) begin @(negedge clk); n++; end
    chk("R2 sof to eof2", n, AT);
    // R1: free-running period
    @(negedge clk); n = 1;
    while (!eof2_o) begin @(negedge clk); n++; end
    chk("R1 frame period", n, FL);
    @(negedge clk);

    poll("R6 empty nak", 1, 0, 0);

    // R3: event hidden until sample
    pulse_evt(0, 4'b0010);
    poll("R3 before sample", 1, 0, 0);
    pass_eof2();
    poll("R3 port2 bit", 1, 1, 8'h04);
    poll("R7 repeat poll", 1, 1, 8'h04);

    pulse_evt(1, 4'b1000);
    pass_eof2();
    poll("R5 multi bits", 1, 1, 8'h15);
    chk("R4 reserved zero", {29'd0, bitmap_o[7:5]}, 0);

    // R7: clear one bit
    clr_i = 5'b00100;
    @(negedge clk);
    clr_i = '0;
    poll("R7 after clear", 1, 1, 8'h11);

    // R8: clear on sample edge with fresh event
    pulse_evt(0, 4'b0001);
    while (!eof2_o) @(negedge clk);
    clr_i = 5'b00011;
    @(negedge clk);
    clr_i = '0;
    poll("R8 clear vs sample", 1, 1, 8'h12);

    // R9 / R10
    configured_i = 1'b0;
    @(negedge clk);
    poll("R9 silent", 0, 0, 0);
    pulse_evt(1, 4'b0100);
    pass_eof2();
    configured_i = 1'b1;
    @(negedge clk);
    poll("R10 wiped", 1, 0, 0);
    pass_eof2();
    poll("R9 ignored events", 1, 0, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule